// File: doc/BRIEF.md
# Block Transfer Buffer Engine

This block is the data path behind multi-byte transfers of a system management bus host. It keeps a 32-entry byte buffer with a position pointer, a byte-count register and a two-bit auxiliary option register, and hands the buffer and a transfer length to a separate bus engine that moves the bytes on the wire. Software works the buffer in one of two ways, chosen by the auxiliary option register.

In buffered mode software writes or reads the whole block through a data port, one byte per access, with the pointer advancing on every access. In single-byte mode software moves one byte per handshake: a byte sits in a one-byte holding register seen through the data port, and each handshake (a write to the status register, signalled here as a strobe) advances the pointer. The engine drives one-cycle flag pulses for byte done, interrupt and device error plus a busy level toward the status register. Checksum generation and the bus protocol itself lie outside the block.

Top module: `blkxfer_engine`

## Requirements
- R1: Before any data-port access the pointer is taken as 0 if it has reached 32, so the 33rd buffered write after a pointer of 0 lands in entry 0.
- R2: Option bit 1 selects buffered mode (1) or single-byte mode (0) and bit 0 enables checksum; exactly these two bits are stored and read back on `aux_q` one cycle after the write.
- R3: In buffered mode each data-port write stores into the entry at the pointer and each data-port read returns that entry, and either access then advances the pointer by one.
- R4: A buffered block-write start with the pointer equal to the byte count issues a bus write of that length and, on a clean completion, pulses interrupt and drops busy; any other pointer value pulses device error, drops busy, issues no bus request and returns the pointer to 0.
- R5: After a buffered block read, the data-port read that brings the pointer to the received count closes the operation, returns the pointer to 0 and drops busy; busy stays high before that read.
- R6: A completed block read writes the received count into the byte-count register; in buffered mode it pulses interrupt, in single-byte mode it places buffer entry 0 on the data port, keeps busy high and pulses byte done.
- R7: In single-byte write mode the start copies the holding byte into entry 0 and pulses byte done; each handshake advances the pointer and either copies the holding byte into the new entry with a byte-done pulse or, when the pointer reaches the byte count, issues the bus write, after whose completion interrupt pulses and busy drops.
- R8: In single-byte read mode a handshake advances the pointer and places the entry at the new position on the data port; without the last-byte input it pulses byte done, with it it pulses interrupt, drops busy and closes the operation.
- R9: A start that selects the raw block read protocol (`start_i2c`=1) with write direction (`start_rd`=0) pulses device error and issues nothing; with read direction its bus length is the byte count capped at 32, while a plain block read always asks for 32.
- R10: After reset busy, all flags, the pointer, the byte count and the option bits are 0; a start while an operation is open first returns the pointer to 0.
- R11: A bus completion with error during any transfer pulses device error, drops busy, closes the operation and returns the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aux_wr | input | 1 | Option register write strobe |
| aux_wdata | input | 2 | Option write data: bit 1 buffered mode, bit 0 checksum enable |
| aux_q | output | 2 | Option register contents |
| cnt_wr | input | 1 | Byte-count register write strobe |
| cnt_wdata | input | 8 | Byte-count write data |
| cnt_q | output | 8 | Byte-count register contents |
| blk_wr | input | 1 | Data-port write strobe |
| blk_wdata | input | 8 | Data-port write data |
| blk_rd | input | 1 | Data-port read strobe (advances the pointer) |
| blk_rdata | output | 8 | Data-port read value |
| hs_wr | input | 1 | Status-write handshake strobe |
| last_byte | input | 1 | Last-byte control level, sampled with a read handshake |
| start | input | 1 | Start strobe |
| start_rd | input | 1 | Direction of the started transfer, 1 = read |
| start_i2c | input | 1 | 1 = raw block read protocol, 0 = block data protocol |
| bus_req | output | 1 | One-cycle request to the bus engine |
| bus_rd | output | 1 | Direction of the request, 1 = read |
| bus_len | output | 6 | Byte length of the request |
| bus_ridx | input | 5 | Buffer entry the bus engine reads |
| bus_rdata | output | 8 | Buffer entry selected by bus_ridx |
| bus_we | input | 1 | Bus engine buffer write enable |
| bus_widx | input | 5 | Buffer entry the bus engine writes |
| bus_wdata | input | 8 | Byte written by the bus engine |
| bus_done | input | 1 | Bus engine completion strobe |
| bus_err | input | 1 | Error qualifier of bus_done |
| bus_rcnt | input | 6 | Bytes received, qualifies a read completion |
| busy | output | 1 | Host-busy level |
| flag_byte_done | output | 1 | Byte-done set pulse |
| flag_intr | output | 1 | Interrupt set pulse |
| flag_dev_err | output | 1 | Device-error set pulse |

## Verification
The bench aims at the pointer boundaries: a 33rd buffered write, which a design without the wrap would push outside the buffer and lose, and a block-write start one byte short of the count, which a lax compare would send with a stale byte. It opens a single-byte read, advances it twice and then starts a buffered write with a zero count; a design that keeps the old pointer reports a device error instead of sending. Single-byte reads end on the last-byte handshake, where an off-by-one shows up as a wrong byte or a missing interrupt, and bus errors and the rejected raw-write start are checked for a device error with busy dropped and no request issued.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WAIT_WR = 3'd1,
      ST_WAIT_RD = 3'd2,
      ST_OPEN_WR = 3'd3,
      ST_OPEN_RD = 3'd4
   } xfer_st_t;

   localparam int unsigned AUX_BIT_PEC = 0;
   localparam int unsigned AUX_BIT_BUF = 1;
endpackage

// File: rtl/blkxfer_buf.sv
module blkxfer_buf #(
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned DW        = 8,
   parameter int unsigned NRD       = 4,
   parameter bit          CLR_STORE = 1'b1,
   localparam int unsigned AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic [AW-1:0]     a_idx,
   input  logic [DW-1:0]     a_data,
   input  logic              b_en,
   input  logic [AW-1:0]     b_idx,
   input  logic [DW-1:0]     b_data,
   input  logic [NRD*AW-1:0] rd_idx,
   output logic [NRD*DW-1:0] rd_data
);
   logic [DW-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic          hit_a, hit_b;
      logic [DW-1:0] nxt;
      assign hit_a = a_en && (a_idx == AW'(e));
      assign hit_b = b_en && (b_idx == AW'(e));
      assign nxt   = hit_a ? a_data : b_data;
      if (CLR_STORE) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)              mem[e] <= '0;
            else if (hit_a || hit_b) mem[e] <= nxt;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit_a || hit_b) mem[e] <= nxt;
         end
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r*DW +: DW] = mem[rd_idx[r*AW +: AW]];
   end
endmodule

// File: rtl/blkxfer_len.sv
module blkxfer_len #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CW    = 8,
   localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
   input  logic          is_rd,
   input  logic          is_i2c,
   input  logic [CW-1:0] cnt,
   output logic [LW-1:0] len
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   logic [LW-1:0] capped;

   assign capped = (cnt > DEPTH_C) ? LW'(DEPTH) : LW'(cnt);
   assign len    = (is_rd && !is_i2c) ? LW'(DEPTH) : capped;
endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
   import blkxfer_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned DW    = 8,
   parameter int unsigned CW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned IW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          aux_wr,
   input  logic [1:0]    aux_wdata,
   output logic [1:0]    aux_q,
   input  logic          cnt_wr,
   input  logic [CW-1:0] cnt_wdata,
   output logic [CW-1:0] cnt_q,
   input  logic          blk_wr,
   input  logic [DW-1:0] blk_wdata,
   input  logic          blk_rd,
   output logic [DW-1:0] blk_rdata,
   input  logic          hs_wr,
   input  logic          last_byte,
   input  logic          start,
   input  logic          start_rd,
   input  logic          start_i2c,
   input  logic          bus_done,
   input  logic          bus_err,
   input  logic [IW-1:0] bus_rcnt,
   input  logic [IW-1:0] lc_len,
   output logic          lc_rd,
   output logic          lc_i2c,
   input  logic [DW-1:0] rd_blk,
   input  logic [DW-1:0] rd_hs,
   input  logic [DW-1:0] rd_b0,
   output logic [AW-1:0] idx_blk,
   output logic [AW-1:0] idx_hs,
   output logic          wa_en,
   output logic [AW-1:0] wa_idx,
   output logic [DW-1:0] wa_data,
   output logic          bus_req,
   output logic          bus_rd,
   output logic [IW-1:0] bus_len,
   output logic          busy,
   output logic          flag_byte_done,
   output logic          flag_intr,
   output logic          flag_dev_err
);
   xfer_st_t      st;
   logic [IW-1:0] idx;
   logic [DW-1:0] hold;

   logic          buffered, waiting, open_op;
   logic [IW-1:0] idx_eff, idx_eff_inc, nidx, idx_start;
   logic          ev_done, ev_start, ev_hs, ev_bw, ev_br;
   logic          start_bad, start_bwr, start_swr;
   logic          wr_match, hs_send, br_last;

   assign buffered    = aux_q[AUX_BIT_BUF];
   assign waiting     = (st == ST_WAIT_WR) || (st == ST_WAIT_RD);
   assign open_op     = (st == ST_OPEN_WR) || (st == ST_OPEN_RD);
   assign idx_eff     = (idx >= IW'(DEPTH)) ? '0 : idx;
   assign idx_eff_inc = idx_eff + IW'(1);
   assign nidx        = idx + IW'(1);
   assign idx_start   = open_op ? '0 : idx;

   // one event per cycle, fixed priority
   assign ev_done  = bus_done && waiting;
   assign ev_start = start && !waiting && !ev_done;
   assign ev_hs    = hs_wr && !buffered && open_op && !ev_done && !start;
   assign ev_bw    = blk_wr && !ev_done && !ev_start && !ev_hs;
   assign ev_br    = blk_rd && !ev_done && !ev_start && !ev_hs && !blk_wr;

   assign start_bad = start_i2c && !start_rd;
   assign start_bwr = !start_bad && !start_rd && buffered;
   assign start_swr = !start_bad && !start_rd && !buffered;
   assign wr_match  = (CW'(idx_start) == cnt_q);
   assign hs_send   = (st == ST_OPEN_WR) && (CW'(nidx) == cnt_q);
   assign br_last   = (st == ST_OPEN_RD) && (CW'(idx_eff_inc) == cnt_q);

   assign lc_rd  = ev_start && start_rd;
   assign lc_i2c = ev_start && start_i2c;

   assign idx_blk   = idx_eff[AW-1:0];
   assign idx_hs    = nidx[AW-1:0];
   assign blk_rdata = buffered ? rd_blk : hold;

   // buffer write port owned by software side
   always_comb begin
      wa_en   = 1'b0;
      wa_idx  = '0;
      wa_data = hold;
      if (ev_start && start_swr) begin
         wa_en = 1'b1;
      end else if (ev_hs && (st == ST_OPEN_WR) && !hs_send) begin
         wa_en  = 1'b1;
         wa_idx = nidx[AW-1:0];
      end else if (ev_bw && buffered) begin
         wa_en   = 1'b1;
         wa_idx  = idx_eff[AW-1:0];
         wa_data = blk_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st             <= ST_IDLE;
         idx            <= '0;
         hold           <= '0;
         aux_q          <= '0;
         cnt_q          <= '0;
         busy           <= 1'b0;
         bus_req        <= 1'b0;
         bus_rd         <= 1'b0;
         bus_len        <= '0;
         flag_byte_done <= 1'b0;
         flag_intr      <= 1'b0;
         flag_dev_err   <= 1'b0;
      end else begin
         bus_req        <= 1'b0;
         flag_byte_done <= 1'b0;
         flag_intr      <= 1'b0;
         flag_dev_err   <= 1'b0;
         if (aux_wr) aux_q <= aux_wdata;
         if (cnt_wr) cnt_q <= cnt_wdata;

         if (ev_done) begin
            idx <= '0;
            if (bus_err) begin
               flag_dev_err <= 1'b1;
               busy         <= 1'b0;
               st           <= ST_IDLE;
            end else if (st == ST_WAIT_WR) begin
               flag_intr <= 1'b1;
               busy      <= 1'b0;
               st        <= ST_IDLE;
            end else begin
               cnt_q <= CW'(bus_rcnt);
               st    <= ST_OPEN_RD;
               if (buffered) begin
                  flag_intr <= 1'b1;
               end else begin
                  hold           <= rd_b0;
                  flag_byte_done <= 1'b1;
               end
            end
         end else if (ev_start) begin
            idx <= '0;
            if (start_bad) begin
               flag_dev_err <= 1'b1;
               busy         <= 1'b0;
               st           <= ST_IDLE;
            end else if (start_rd) begin
               bus_req <= 1'b1;
               bus_rd  <= 1'b1;
               bus_len <= lc_len;
               busy    <= 1'b1;
               st      <= ST_WAIT_RD;
            end else if (start_bwr) begin
               if (wr_match) begin
                  bus_req <= 1'b1;
                  bus_rd  <= 1'b0;
                  bus_len <= lc_len;
                  busy    <= 1'b1;
                  st      <= ST_WAIT_WR;
               end else begin
                  flag_dev_err <= 1'b1;
                  busy         <= 1'b0;
                  st           <= ST_IDLE;
               end
            end else begin
               flag_byte_done <= 1'b1;
               busy           <= 1'b1;
               st             <= ST_OPEN_WR;
            end
         end else if (ev_hs) begin
            if (st == ST_OPEN_WR) begin
               idx <= nidx;
               if (hs_send) begin
                  bus_req <= 1'b1;
                  bus_rd  <= 1'b0;
                  bus_len <= lc_len;
                  st      <= ST_WAIT_WR;
               end else begin
                  flag_byte_done <= 1'b1;
               end
            end else begin
               hold <= rd_hs;
               if (last_byte) begin
                  idx       <= '0;
                  flag_intr <= 1'b1;
                  busy      <= 1'b0;
                  st        <= ST_IDLE;
               end else begin
                  idx            <= nidx;
                  flag_byte_done <= 1'b1;
               end
            end
         end else if (ev_bw) begin
            if (buffered) begin
               idx <= idx_eff_inc;
            end else begin
               hold <= blk_wdata;
               idx  <= idx_eff;
            end
         end else if (ev_br) begin
            if (buffered && br_last) begin
               idx  <= '0;
               busy <= 1'b0;
               st   <= ST_IDLE;
            end else if (buffered) begin
               idx <= idx_eff_inc;
            end else begin
               idx <= idx_eff;
            end
         end
      end
   end
endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine #(
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned DW        = 8,
   parameter int unsigned CW        = 8,
   parameter bit          CLR_STORE = 1'b1,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned IW       = AW + 1,
   localparam int unsigned NRD      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          aux_wr,
   input  logic [1:0]    aux_wdata,
   output logic [1:0]    aux_q,
   input  logic          cnt_wr,
   input  logic [CW-1:0] cnt_wdata,
   output logic [CW-1:0] cnt_q,
   input  logic          blk_wr,
   input  logic [DW-1:0] blk_wdata,
   input  logic          blk_rd,
   output logic [DW-1:0] blk_rdata,
   input  logic          hs_wr,
   input  logic          last_byte,
   input  logic          start,
   input  logic          start_rd,
   input  logic          start_i2c,
   output logic          bus_req,
   output logic          bus_rd,
   output logic [IW-1:0] bus_len,
   input  logic [AW-1:0] bus_ridx,
   output logic [DW-1:0] bus_rdata,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_widx,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_done,
   input  logic          bus_err,
   input  logic [IW-1:0] bus_rcnt,
   output logic          busy,
   output logic          flag_byte_done,
   output logic          flag_intr,
   output logic          flag_dev_err
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("blkxfer_engine: DEPTH must be a power of two of at least 2");
   end
   if (CW < IW) begin : g_bad_cw
      $error("blkxfer_engine: CW must hold a count of DEPTH");
   end

   logic          lc_rd, lc_i2c;
   logic [IW-1:0] lc_len;
   logic [AW-1:0] idx_blk, idx_hs;
   logic          wa_en;
   logic [AW-1:0] wa_idx;
   logic [DW-1:0] wa_data;
   logic [NRD*AW-1:0] rd_idx;
   logic [NRD*DW-1:0] rd_data;

   // read ports: 0 data port, 1 handshake, 2 entry zero, 3 bus engine
   assign rd_idx    = {bus_ridx, AW'(0), idx_hs, idx_blk};
   assign bus_rdata = rd_data[3*DW +: DW];

   blkxfer_buf #(
      .DEPTH(DEPTH), .DW(DW), .NRD(NRD), .CLR_STORE(CLR_STORE)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_en   (wa_en),
      .a_idx  (wa_idx),
      .a_data (wa_data),
      .b_en   (bus_we),
      .b_idx  (bus_widx),
      .b_data (bus_wdata),
      .rd_idx (rd_idx),
      .rd_data(rd_data)
   );

   blkxfer_len #(.DEPTH(DEPTH), .CW(CW)) u_len (
      .is_rd (lc_rd),
      .is_i2c(lc_i2c),
      .cnt   (cnt_q),
      .len   (lc_len)
   );

   blkxfer_ctrl #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .aux_wr        (aux_wr),
      .aux_wdata     (aux_wdata),
      .aux_q         (aux_q),
      .cnt_wr        (cnt_wr),
      .cnt_wdata     (cnt_wdata),
      .cnt_q         (cnt_q),
      .blk_wr        (blk_wr),
      .blk_wdata     (blk_wdata),
      .blk_rd        (blk_rd),
      .blk_rdata     (blk_rdata),
      .hs_wr         (hs_wr),
      .last_byte     (last_byte),
      .start         (start),
      .start_rd      (start_rd),
      .start_i2c     (start_i2c),
      .bus_done      (bus_done),
      .bus_err       (bus_err),
      .bus_rcnt      (bus_rcnt),
      .lc_len        (lc_len),
      .lc_rd         (lc_rd),
      .lc_i2c        (lc_i2c),
      .rd_blk        (rd_data[0*DW +: DW]),
      .rd_hs         (rd_data[1*DW +: DW]),
      .rd_b0         (rd_data[2*DW +: DW]),
      .idx_blk       (idx_blk),
      .idx_hs        (idx_hs),
      .wa_en         (wa_en),
      .wa_idx        (wa_idx),
      .wa_data       (wa_data),
      .bus_req       (bus_req),
      .bus_rd        (bus_rd),
      .bus_len       (bus_len),
      .busy          (busy),
      .flag_byte_done(flag_byte_done),
      .flag_intr     (flag_intr),
      .flag_dev_err  (flag_dev_err)
   );
endmodule

// File: rtl/blkxfer_engine_chk.sv
module blkxfer_engine_chk #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned IW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          aux_wr,
   input logic [1:0]    aux_wdata,
   input logic [1:0]    aux_q,
   input logic          bus_req,
   input logic          bus_rd,
   input logic [IW-1:0] bus_len,
   input logic          bus_done,
   input logic          bus_err,
   input logic          busy,
   input logic          flag_byte_done,
   input logic          flag_intr,
   input logic          flag_dev_err
);
   logic pend_q, pend_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         pend_rd <= 1'b0;
      end else if (bus_req) begin
         pend_q  <= 1'b1;
         pend_rd <= bus_rd;
      end else if (bus_done) begin
         pend_q  <= 1'b0;
      end
   end

   p_reset_clear_r10: assert property (@(posedge clk)
      !rst_n |=> (!busy && !flag_intr && !flag_dev_err && !flag_byte_done && aux_q == 2'b00));

   p_aux_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      aux_wr |=> (aux_q == $past(aux_wdata)));

   p_len_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_len <= IW'(DEPTH)));

   p_busy_on_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy);

   p_write_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_done && !bus_err && pend_q && !pend_rd) |=> (flag_intr && !busy));

   p_err_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_done && bus_err && pend_q) |=> (flag_dev_err && !busy));

   p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_byte_done, flag_intr, flag_dev_err}));
endmodule

bind blkxfer_engine blkxfer_engine_chk #(.DEPTH(DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .aux_wr        (aux_wr),
   .aux_wdata     (aux_wdata),
   .aux_q         (aux_q),
   .bus_req       (bus_req),
   .bus_rd        (bus_rd),
   .bus_len       (bus_len),
   .bus_done      (bus_done),
   .bus_err       (bus_err),
   .busy          (busy),
   .flag_byte_done(flag_byte_done),
   .flag_intr     (flag_intr),
   .flag_dev_err  (flag_dev_err)
);

// File: tb/blkxfer_engine_test.sv
`timescale 1ns/1ps
module blkxfer_engine_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       aux_wr = 0;      logic [1:0] aux_wdata = 0; logic [1:0] aux_q;
   logic       cnt_wr = 0;      logic [7:0] cnt_wdata = 0; logic [7:0] cnt_q;
   logic       blk_wr = 0;      logic [7:0] blk_wdata = 0;
   logic       blk_rd = 0;      logic [7:0] blk_rdata;
   logic       hs_wr = 0, last_byte = 0;
   logic       start = 0, start_rd = 0, start_i2c = 0;
   logic       bus_req, bus_rd;  logic [5:0] bus_len;
   logic [4:0] bus_ridx = 0;     logic [7:0] bus_rdata;
   logic       bus_we = 0;       logic [4:0] bus_widx = 0; logic [7:0] bus_wdata = 0;
   logic       bus_done = 0, bus_err = 0; logic [5:0] bus_rcnt = 0;
   logic       busy, flag_byte_done, flag_intr, flag_dev_err;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] dat [32];

   always #2.5 clk = ~clk;

   blkxfer_engine uut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   task automatic set_aux(input logic [1:0] v);
      @(negedge clk); aux_wr = 1; aux_wdata = v; @(negedge clk); aux_wr = 0;
   endtask
   task automatic set_cnt(input int v);
      @(negedge clk); cnt_wr = 1; cnt_wdata = 8'(v); @(negedge clk); cnt_wr = 0;
   endtask
   task automatic bw(input logic [7:0] v);
      @(negedge clk); blk_wr = 1; blk_wdata = v; @(negedge clk); blk_wr = 0;
   endtask
   task automatic br(output logic [7:0] v);
      @(negedge clk); blk_rd = 1; v = blk_rdata; @(negedge clk); blk_rd = 0;
   endtask
   task automatic hs(input bit last);
      @(negedge clk); hs_wr = 1; last_byte = last; @(negedge clk); hs_wr = 0; last_byte = 0;
   endtask
   task automatic go(input bit rd, input bit i2c);
      @(negedge clk); start = 1; start_rd = rd; start_i2c = i2c;
      @(negedge clk); start = 0;
   endtask
   // serve a read request with k bytes from dat[]
   task automatic serve_rd(input int k, input bit err);
      for (int i = 0; i < k; i++) begin
         @(negedge clk); bus_we = 1; bus_widx = 5'(i); bus_wdata = dat[i];
      end
      @(negedge clk); bus_we = 0; bus_done = 1; bus_err = err; bus_rcnt = 6'(k);
      @(negedge clk); bus_done = 0; bus_err = 0;
   endtask
   // compare the buffer seen by the bus engine, then complete
   task automatic serve_wr(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         bus_ridx = 5'(i); #0.1;
         chk(bus_rdata == dat[i], req, bus_rdata, dat[i]);
      end
      @(negedge clk); bus_done = 1;
      @(negedge clk); bus_done = 0;
   endtask

   task automatic buf_write(input int n, input string req);
      for (int i = 0; i < n; i++) bw(dat[i]);
      set_cnt(n);
      go(0, 0);
      chk(bus_req && !bus_rd, req, bus_req, 1);
      chk(bus_len == 6'(n), req, bus_len, n);
      serve_wr(n, req);
      chk(flag_intr && !busy, req, {flag_intr, busy}, 2);
   endtask

   task automatic buf_read(input int k, input string req);
      logic [7:0] v;
      go(1, 0);
      chk(bus_req && bus_rd && bus_len == 6'd32, "R9 block len", bus_len, 32);
      serve_rd(k, 0);
      chk(flag_intr && busy, "R6 buffered done", {flag_intr, busy}, 3);
      chk(cnt_q == 8'(k), "R6 count", cnt_q, k);
      for (int i = 0; i < k; i++) begin
         if (i == k - 1) chk(busy, "R5 busy before end", busy, 1);
         br(v);
         chk(v == dat[i], req, v, dat[i]);
      end
      chk(!busy, "R5 busy after end", busy, 0);
   endtask

   task automatic byte_write(input int n);
      bw(dat[0]);
      set_cnt(n);
      go(0, 0);
      chk(flag_byte_done && busy, "R7 start", {flag_byte_done, busy}, 3);
      for (int i = 1; i < n; i++) begin
         bw(dat[i]);
         hs(0);
         chk(flag_byte_done && !bus_req, "R7 step", flag_byte_done, 1);
      end
      hs(0);
      chk(bus_req && bus_len == 6'(n), "R7 send", bus_len, n);
      serve_wr(n, "R7 data");
      chk(flag_intr && !busy, "R7 finish", {flag_intr, busy}, 2);
   endtask

   task automatic byte_read(input int k);
      go(1, 0);
      serve_rd(k, 0);
      chk(flag_byte_done && busy && blk_rdata == dat[0], "R6 byte0", blk_rdata, dat[0]);
      chk(cnt_q == 8'(k), "R6 count", cnt_q, k);
      for (int i = 1; i < k; i++) begin
         hs(i == k - 1);
         chk(blk_rdata == dat[i], "R8 data", blk_rdata, dat[i]);
         if (i == k - 1) chk(flag_intr && !busy, "R8 last", {flag_intr, busy}, 2);
         else            chk(flag_byte_done && busy, "R8 step", {flag_byte_done, busy}, 3);
      end
   endtask

   task automatic fill_rand();
      for (int i = 0; i < 32; i++) dat[i] = 8'($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL R10 watchdog expired: actual 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk(!busy && !flag_intr && !flag_dev_err && !flag_byte_done, "R10 flags", busy, 0);
      chk(aux_q == 0 && cnt_q == 0, "R10 regs", {aux_q, cnt_q}, 0);

      // R2 option readback
      set_aux(2'b11); chk(aux_q == 2'b11, "R2", aux_q, 3);
      set_aux(2'b01); chk(aux_q == 2'b01, "R2", aux_q, 1);
      set_aux(2'b10); chk(aux_q == 2'b10, "R2", aux_q, 2);

      // R3 R4 buffered write
      fill_rand(); buf_write(7, "R3 R4 buffered write");

      // R4 mismatch, then pointer back at 0
      fill_rand();
      for (int i = 0; i < 4; i++) bw(dat[i]);
      set_cnt(5);
      go(0, 0);
      chk(flag_dev_err && !bus_req && !busy, "R4 mismatch", {flag_dev_err, bus_req}, 2);
      buf_write(3, "R4 after mismatch");

      // R5 R6 buffered read
      fill_rand(); buf_read(9, "R3 R5 buffered read");

      // R1 wrap: 33rd write lands in entry 0
      fill_rand();
      for (int i = 0; i < 32; i++) bw(8'(i));
      bw(dat[0]);
      set_cnt(1);
      go(0, 0);
      chk(bus_req && bus_len == 6'd1, "R1 wrap len", bus_len, 1);
      serve_wr(1, "R1 wrap data");

      // R7 R8 single-byte mode
      set_aux(2'b00);
      fill_rand(); byte_write(5);
      fill_rand(); byte_write(1);
      fill_rand(); byte_read(6);

      // R9 raw block read protocol
      go(0, 1);
      chk(flag_dev_err && !bus_req && !busy, "R9 write rejected", {flag_dev_err, bus_req}, 2);
      set_aux(2'b10);
      set_cnt(40);
      go(1, 1);
      chk(bus_req && bus_len == 6'd32, "R9 cap", bus_len, 32);
      fill_rand(); serve_rd(3, 0);
      for (int i = 0; i < 3; i++) begin br(v); chk(v == dat[i], "R9 data", v, dat[i]); end
      set_cnt(5);
      go(1, 1);
      chk(bus_req && bus_len == 6'd5, "R9 short", bus_len, 5);
      serve_rd(2, 0);
      br(v); br(v);
      chk(!busy, "R5 i2c drained", busy, 1'b0);

      // R11 bus error
      go(1, 0);
      serve_rd(0, 1);
      chk(flag_dev_err && !busy, "R11 read err", {flag_dev_err, busy}, 2);
      fill_rand();
      for (int i = 0; i < 2; i++) bw(dat[i]);
      set_cnt(2);
      go(0, 0);
      serve_rd(0, 1);
      chk(flag_dev_err && !busy, "R11 write err", {flag_dev_err, busy}, 2);
      fill_rand(); buf_write(4, "R11 pointer reset");

      // R10 start while open resets the pointer
      set_aux(2'b00);
      fill_rand();
      go(1, 0); serve_rd(6, 0);
      hs(0); hs(0);
      set_aux(2'b10);
      set_cnt(0);
      go(0, 0);
      chk(bus_req && !flag_dev_err && bus_len == 0, "R10 open start", {bus_req, flag_dev_err}, 2);
      serve_wr(0, "R10");
      chk(flag_intr && !busy, "R10 finish", flag_intr, 1);

      // random mix
      for (int it = 0; it < 24; it++) begin
         int n;
         logic [1:0] kind;
         n = 2 + int'($urandom % 31);
         kind = 2'($urandom);
         fill_rand();
         set_aux({kind[1], 1'($urandom)});
         case (kind)
            2'b10: buf_write(n, "R3 R4 random write");
            2'b11: buf_read(n, "R3 R5 random read");
            2'b00: byte_write(n);
            default: byte_read(n);
         endcase
      end

      finished = 1;
      summary();
      $finish;
   end
endmodule